// File: doc/BRIEF.md
# Dual Redundant Link Frame Checker

This block receives the same 320-bit acquisition frame over two redundant serial links, each already deserialised and decoded upstream. Each link delivers one frame per acquisition period, marked by a one-cycle strobe. The block waits until both copies have arrived, or until a bounded window expires. It then runs a CRC-32 over each copy in fixed-width chunks, one chunk per clock. Each copy is checked against the expected card identifier and against the frame number that should follow on its link.

After the checks the block forwards the eight channel measurements of one trusted copy and updates a set of saturating error counters. There are counters for CRC failures on each link, for a CRC disagreement between two good copies, for a foreign card identifier, for a break in frame numbering, and for frames lost on each link. Downstream sum and threshold logic consumes the forwarded data. Supervision logic reads the counters.

The controller is a four-state machine:
- `S_IDLE`: no copy held.
- `S_WAIT`: one copy held, waiting for its twin.
- `S_CRC`: chunked CRC evaluation of both held copies.
- `S_CHECK`: verdicts, selection and counter update.

The transitions are:
- T_FIRST: `S_IDLE`→`S_WAIT`, one strobe seen.
- T_PAIR: `S_IDLE`/`S_WAIT`→`S_CRC`, both copies held.
- T_TIMEOUT: `S_WAIT`→`S_CRC`, window expired.
- T_CRC_DONE: `S_CRC`→`S_CHECK`, last chunk processed.
- T_REPORT: `S_CHECK`→`S_IDLE`.

Top module: `dual_link_frame_checker`

## Requirements
- R1: The CRC of a copy is computed over frame bits [319:32], taken most significant bit first. It uses polynomial 0x04C11DB7 with an all-ones start value, no bit reflection and no final inversion. The result is compared with bits [31:0]. Each held copy that fails this comparison adds one to its own link's CRC error counter.
- R2: The frame fields sit at these positions:
  - frame number: [319:304]
  - card identifier: [303:288]
  - status: [287:256]
  - channel k (k=0..7): 8-bit count at [255-20k -: 8] and 12-bit ADC value at [247-20k -: 12]
  - DAC values: [95:32]
- R3: A copy is valid when it is held, passes CRC and carries a card identifier equal to `card_id_exp`. The card error counter rises by one in each period in which at least one held, CRC-good copy carries another identifier.
- R4: When link A's copy is valid, it is forwarded; otherwise link B's copy is forwarded if valid; with no valid copy, `out_valid` stays low for that period. `out_valid` is a one-cycle pulse. At that pulse, `out_counts` carries channel k at [63-8k -: 8] and `out_adcs` carries channel k at [95-12k -: 12].
- R5: The CRC disagreement counter rises by one when both copies are held and CRC-good but their bits [31:0] differ.
- R6: A period opens with the first accepted strobe. The other link's strobe is accepted for WAIT_CYC cycles. If it does not arrive, that link's lost counter rises by one. `out_valid` is high in the cycle after the tenth rising edge following the edge that samples the strobe completing the pair.
- R7: Each link expects the frame number one above its previous reference, modulo 2^16. The reference advances by one in every period where the link has no valid copy. A valid copy with another number raises the frame number error counter by one per period and adds (number − expected) mod 2^16 to that link's lost counter. The first valid copy after reset sets the reference without error.
- R8: Every counter stops at its all-ones value and never wraps.
- R9: A high `cnt_clr` at a rising edge sets all counters to zero at that edge and takes precedence over any increment. It leaves frame number references untouched.
- R10: A strobe on a link whose copy is already held in the open period is ignored, as are strobes during CRC evaluation and checking. The first held copy is the one that is judged and forwarded.
- R11: After reset `out_valid` is low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| card_id_exp | input | 16 | Card identifier that valid frames must carry |
| a_strobe | input | 1 | Frame present on link A |
| a_frame | input | 320 | Frame word of link A |
| b_strobe | input | 1 | Frame present on link B |
| b_frame | input | 320 | Frame word of link B |
| out_valid | output | 1 | Forwarded data valid pulse |
| out_frame_id | output | 16 | Frame number of the forwarded copy |
| out_counts | output | 64 | Eight 8-bit channel counts |
| out_adcs | output | 96 | Eight 12-bit channel ADC values |
| crc_err_a | output | CNT_W | CRC failures on link A |
| crc_err_b | output | CNT_W | CRC failures on link B |
| crc_diff | output | CNT_W | Good-CRC disagreements between links |
| card_err | output | CNT_W | Periods with a foreign card identifier |
| fid_err | output | CNT_W | Periods with a frame number break |
| lost_a | output | CNT_W | Frames lost on link A |
| lost_b | output | CNT_W | Frames lost on link B |

## Verification
Some properties are checked on every cycle:
- the forwarded-data strobe never lasts two cycles;
- counters never decrease except through the clear, which zeroes them all on the next cycle;
- the per-event counters never rise by more than one per cycle.

Other behaviour only the bench's scenarios can show: which copy is chosen when CRCs, card identifiers or arrival differ, how many frames a numbering jump adds to each lost counter, the exact output latency, saturation under repeated faults, and the rejection of a second strobe on a link already held.

// File: rtl/dlfc_pkg.sv
package dlfc_pkg;
    // Frame geometry; positions are fixed by the frame format
    localparam int FRAME_W  = 320;
    localparam int CRC_W    = 32;
    localparam int CRC_SPAN = FRAME_W - CRC_W;
    localparam int ID_W     = 16;
    localparam int CHAN_N   = 8;
    localparam int CNT8_W   = 8;
    localparam int ADC_W    = 12;
    localparam int CHAN_W   = CNT8_W + ADC_W;
    localparam int FID_HI   = 319;
    localparam int CARD_HI  = 303;
    localparam int CHAN_HI  = 255;
    localparam int NUM_LINK = 2;
    localparam int NUM_CNT  = 7;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

    // Counter slots
    localparam int C_CRC_A = 0;
    localparam int C_CRC_B = 1;
    localparam int C_DIFF  = 2;
    localparam int C_CARD  = 3;
    localparam int C_FID   = 4;
    localparam int C_LOST0 = 5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_CRC,
        S_CHECK
    } dlfc_state_t;
endpackage

// File: rtl/dlfc_crc_step.sv
module dlfc_crc_step
    import dlfc_pkg::*;
#(
    parameter int CHUNK = 32
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [CHUNK-1:0] data,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    // Bit-serial LFSR unrolled over one chunk, MSB first
    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int i = CHUNK - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ CRC_POLY;
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/dlfc_copy_eval.sv
module dlfc_copy_eval
    import dlfc_pkg::*;
(
    input  logic [FRAME_W-1:0] frame,
    input  logic [CRC_W-1:0]   crc_calc,
    input  logic               present,
    input  logic [ID_W-1:0]    card_exp,
    input  logic               have_ref,
    input  logic [ID_W-1:0]    exp_id,
    output logic               crc_ok,
    output logic               card_bad,
    output logic               valid,
    output logic               id_jump,
    output logic [ID_W-1:0]    gap
);
    logic [ID_W-1:0] fid;
    logic [ID_W-1:0] card;

    assign fid  = frame[FID_HI -: ID_W];
    assign card = frame[CARD_HI -: ID_W];

    always_comb begin
        crc_ok   = present && (crc_calc == frame[CRC_W-1:0]);
        card_bad = crc_ok && (card != card_exp);
        valid    = crc_ok && (card == card_exp);
        id_jump  = valid && have_ref && (fid != exp_id);
        gap      = fid - exp_id;
    end
endmodule

// File: rtl/dlfc_sat_counter.sv
module dlfc_sat_counter #(
    parameter int W  = 16,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc_en,
    input  logic [AW-1:0] inc_amt,
    output logic [W-1:0]  value
);
    localparam int SW = ((W > AW) ? W : AW) + 1;
    localparam logic [SW-1:0] MAXV = SW'({W{1'b1}});

    logic [SW-1:0] sum;

    assign sum = SW'(value) + SW'(inc_amt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc_en) begin
            value <= (sum > MAXV) ? {W{1'b1}} : sum[W-1:0];
        end
    end
endmodule

// File: rtl/dual_link_frame_checker.sv
module dual_link_frame_checker
    import dlfc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int WAIT_CYC  = 64,
    parameter int CRC_CHUNK = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_clr,
    input  logic [ID_W-1:0]         card_id_exp,
    input  logic                    a_strobe,
    input  logic [FRAME_W-1:0]      a_frame,
    input  logic                    b_strobe,
    input  logic [FRAME_W-1:0]      b_frame,
    output logic                    out_valid,
    output logic [ID_W-1:0]         out_frame_id,
    output logic [CHAN_N*CNT8_W-1:0] out_counts,
    output logic [CHAN_N*ADC_W-1:0] out_adcs,
    output logic [CNT_W-1:0]        crc_err_a,
    output logic [CNT_W-1:0]        crc_err_b,
    output logic [CNT_W-1:0]        crc_diff,
    output logic [CNT_W-1:0]        card_err,
    output logic [CNT_W-1:0]        fid_err,
    output logic [CNT_W-1:0]        lost_a,
    output logic [CNT_W-1:0]        lost_b
);
    localparam int NCHUNK = CRC_SPAN / CRC_CHUNK;
    localparam int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int WAIT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NCHUNK - 1);
    localparam logic [WAIT_W-1:0] LAST_WAIT = WAIT_W'(WAIT_CYC - 1);

    dlfc_state_t st_q, st_d;

    logic [NUM_LINK-1:0] strb;
    logic [FRAME_W-1:0]  frm_in  [NUM_LINK];
    logic [FRAME_W-1:0]  frm_q   [NUM_LINK];
    logic [NUM_LINK-1:0] has_q;
    logic [NUM_LINK-1:0] take;
    logic [WAIT_W-1:0]   wait_q;
    logic [IDX_W-1:0]    idx_q;
    logic [CRC_W-1:0]    crc_q   [NUM_LINK];
    logic [CRC_W-1:0]    crc_nx  [NUM_LINK];
    logic [CRC_CHUNK-1:0] chunk  [NUM_LINK];
    logic [NUM_LINK-1:0] have_ref_q;
    logic [ID_W-1:0]     exp_id_q [NUM_LINK];

    logic [NUM_LINK-1:0] crc_ok, card_bad, valid, id_jump;
    logic [ID_W-1:0]     gap [NUM_LINK];

    logic accepting, pair_done, timeout, reporting;

    assign strb      = {b_strobe, a_strobe};
    assign frm_in[0] = a_frame;
    assign frm_in[1] = b_frame;

    assign accepting = (st_q == S_IDLE) || (st_q == S_WAIT);
    assign take      = strb & ~has_q & {NUM_LINK{accepting}};
    assign pair_done = &(has_q | take);
    assign timeout   = (st_q == S_WAIT) && (wait_q == LAST_WAIT);
    assign reporting = (st_q == S_CHECK);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (pair_done) begin
                    st_d = S_CRC;            // T_PAIR
                end else if (|take) begin
                    st_d = S_WAIT;           // T_FIRST
                end
            end
            S_WAIT: begin
                if (pair_done || timeout) begin
                    st_d = S_CRC;            // T_PAIR / T_TIMEOUT
                end
            end
            S_CRC: begin
                if (idx_q == LAST_IDX) begin
                    st_d = S_CHECK;          // T_CRC_DONE
                end
            end
            S_CHECK: begin
                st_d = S_IDLE;               // T_REPORT
            end
            default: st_d = S_IDLE;
        endcase
    end

    // ---------------- per-link CRC and verdict ----------------
    for (genvar g = 0; g < NUM_LINK; g++) begin : g_link
        logic [FRAME_W-1:0] shifted;
        assign shifted  = frm_q[g] << (idx_q * CRC_CHUNK);
        assign chunk[g] = shifted[FRAME_W-1 -: CRC_CHUNK];

        dlfc_crc_step #(.CHUNK(CRC_CHUNK)) u_crc (
            .crc_in  (crc_q[g]),
            .data    (chunk[g]),
            .crc_out (crc_nx[g])
        );

        dlfc_copy_eval u_eval (
            .frame    (frm_q[g]),
            .crc_calc (crc_q[g]),
            .present  (has_q[g]),
            .card_exp (card_id_exp),
            .have_ref (have_ref_q[g]),
            .exp_id   (exp_id_q[g]),
            .crc_ok   (crc_ok[g]),
            .card_bad (card_bad[g]),
            .valid    (valid[g]),
            .id_jump  (id_jump[g]),
            .gap      (gap[g])
        );
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_LINK; k++) begin
                frm_q[k]    <= '0;
                crc_q[k]    <= CRC_INIT;
                exp_id_q[k] <= '0;
            end
            has_q      <= '0;
            have_ref_q <= '0;
            wait_q     <= '0;
            idx_q      <= '0;
        end else begin
            for (int k = 0; k < NUM_LINK; k++) begin
                if (take[k]) begin
                    frm_q[k] <= frm_in[k];
                    has_q[k] <= 1'b1;
                end
                if (st_q == S_CRC) begin
                    crc_q[k] <= crc_nx[k];
                end else begin
                    crc_q[k] <= CRC_INIT;
                end
                if (reporting) begin
                    if (valid[k]) begin
                        exp_id_q[k]   <= frm_q[k][FID_HI -: ID_W] + 1'b1;
                        have_ref_q[k] <= 1'b1;
                    end else if (have_ref_q[k]) begin
                        exp_id_q[k] <= exp_id_q[k] + 1'b1;
                    end
                end
            end
            if (reporting) begin
                has_q <= '0;
            end
            wait_q <= (st_q == S_WAIT) ? wait_q + 1'b1 : '0;
            idx_q  <= (st_q == S_CRC)  ? idx_q + 1'b1  : '0;
        end
    end

    // ---------------- selection and field extraction ----------------
    logic [FRAME_W-1:0]          sel_frame;
    logic [CHAN_N*CNT8_W-1:0]    counts_nx;
    logic [CHAN_N*ADC_W-1:0]     adcs_nx;

    assign sel_frame = valid[0] ? frm_q[0] : frm_q[1];

    for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
        assign counts_nx[CHAN_N*CNT8_W-1-c*CNT8_W -: CNT8_W] =
            sel_frame[CHAN_HI - c*CHAN_W -: CNT8_W];
        assign adcs_nx[CHAN_N*ADC_W-1-c*ADC_W -: ADC_W] =
            sel_frame[CHAN_HI - CNT8_W - c*CHAN_W -: ADC_W];
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_frame_id <= '0;
            out_counts   <= '0;
            out_adcs     <= '0;
        end else begin
            out_valid <= reporting && (|valid);
            if (reporting && (|valid)) begin
                out_frame_id <= sel_frame[FID_HI -: ID_W];
                out_counts   <= counts_nx;
                out_adcs     <= adcs_nx;
            end
        end
    end

    // ---------------- error counters ----------------
    logic [NUM_CNT-1:0] cnt_en;
    logic [ID_W-1:0]    cnt_amt [NUM_CNT];
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    always_comb begin
        cnt_en[C_CRC_A] = reporting && has_q[0] && !crc_ok[0];
        cnt_en[C_CRC_B] = reporting && has_q[1] && !crc_ok[1];
        cnt_en[C_DIFF]  = reporting && (&crc_ok) &&
                          (frm_q[0][CRC_W-1:0] != frm_q[1][CRC_W-1:0]);
        cnt_en[C_CARD]  = reporting && (|card_bad);
        cnt_en[C_FID]   = reporting && (|id_jump);
        for (int k = 0; k < C_LOST0; k++) begin
            cnt_amt[k] = ID_W'(1);
        end
        for (int k = 0; k < NUM_LINK; k++) begin
            cnt_en[C_LOST0+k]  = reporting && (!has_q[k] || id_jump[k]);
            cnt_amt[C_LOST0+k] = id_jump[k] ? gap[k] : ID_W'(1);
        end
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        dlfc_sat_counter #(.W(CNT_W), .AW(ID_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (cnt_clr),
            .inc_en  (cnt_en[n]),
            .inc_amt (cnt_amt[n]),
            .value   (cnt_val[n])
        );
    end

    assign crc_err_a = cnt_val[C_CRC_A];
    assign crc_err_b = cnt_val[C_CRC_B];
    assign crc_diff  = cnt_val[C_DIFF];
    assign card_err  = cnt_val[C_CARD];
    assign fid_err   = cnt_val[C_FID];
    assign lost_a    = cnt_val[C_LOST0];
    assign lost_b    = cnt_val[C_LOST0+1];
endmodule

// File: rtl/dlfc_checker.sv
module dlfc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_clr,
    input logic             out_valid,
    input logic [CNT_W-1:0] crc_err_a,
    input logic [CNT_W-1:0] crc_err_b,
    input logic [CNT_W-1:0] crc_diff,
    input logic [CNT_W-1:0] card_err,
    input logic [CNT_W-1:0] fid_err,
    input logic [CNT_W-1:0] lost_a,
    input logic [CNT_W-1:0] lost_b
);
    // R4: forwarded data strobe lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9: clear zeroes every counter
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (crc_err_a == '0 && crc_err_b == '0 && crc_diff == '0 &&
                     card_err == '0 && fid_err == '0 && lost_a == '0 && lost_b == '0));

    // R8: without clear, counters never move down (no wrap)
    a_r8_no_wrap_crc: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (crc_err_a >= $past(crc_err_a) && crc_err_b >= $past(crc_err_b)));

    a_r8_no_wrap_misc: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (crc_diff >= $past(crc_diff) && card_err >= $past(card_err) &&
                      fid_err >= $past(fid_err)));

    a_r8_no_wrap_lost: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (lost_a >= $past(lost_a) && lost_b >= $past(lost_b)));

    // R1: a link's CRC counter rises at most one per cycle
    a_r1_crc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ({1'b0, crc_err_a} <= {1'b0, $past(crc_err_a)} + 1'b1 &&
                      {1'b0, crc_err_b} <= {1'b0, $past(crc_err_b)} + 1'b1));

    // R3: card counter rises at most one per cycle
    a_r3_card_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ({1'b0, card_err} <= {1'b0, $past(card_err)} + 1'b1));

    // R5: disagreement counter rises at most one per cycle
    a_r5_diff_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ({1'b0, crc_diff} <= {1'b0, $past(crc_diff)} + 1'b1));

    // R7: frame number error counter rises at most one per cycle
    a_r7_fid_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ({1'b0, fid_err} <= {1'b0, $past(fid_err)} + 1'b1));
endmodule

bind dual_link_frame_checker dlfc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_clr   (cnt_clr),
    .out_valid (out_valid),
    .crc_err_a (crc_err_a),
    .crc_err_b (crc_err_b),
    .crc_diff  (crc_diff),
    .card_err  (card_err),
    .fid_err   (fid_err),
    .lost_a    (lost_a),
    .lost_b    (lost_b)
);

// File: tb/dual_link_frame_checker_tb_top.sv
module dual_link_frame_checker_tb_top;
    import dlfc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 4;
    localparam int TB_WAIT    = 16;
    localparam int CMAX       = (1 << TB_CNT_W) - 1;
    localparam logic [15:0] CARD = 16'hC0DE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_clr = 1'b0;
    logic a_strobe = 1'b0, b_strobe = 1'b0;
    logic [319:0] a_frame = '0, b_frame = '0;
    logic out_valid;
    logic [15:0] out_frame_id;
    logic [63:0] out_counts;
    logic [95:0] out_adcs;
    logic [TB_CNT_W-1:0] crc_err_a, crc_err_b, crc_diff, card_err, fid_err, lost_a, lost_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_link_frame_checker #(.CNT_W(TB_CNT_W), .WAIT_CYC(TB_WAIT), .CRC_CHUNK(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .card_id_exp(CARD),
        .a_strobe(a_strobe), .a_frame(a_frame), .b_strobe(b_strobe), .b_frame(b_frame),
        .out_valid(out_valid), .out_frame_id(out_frame_id), .out_counts(out_counts),
        .out_adcs(out_adcs), .crc_err_a(crc_err_a), .crc_err_b(crc_err_b),
        .crc_diff(crc_diff), .card_err(card_err), .fid_err(fid_err),
        .lost_a(lost_a), .lost_b(lost_b)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [15:0] fid;
        logic [63:0] cnts;
        logic [95:0] adcs;
    } item_t;
    item_t exp_q[$];

    // model state
    int mc[7];
    bit href[2];
    logic [15:0] eid[2];

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // R1: reference CRC, bitwise
    function automatic logic [31:0] tb_crc(logic [319:0] f);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 319; i >= 32; i--) begin
            logic fb = c[31] ^ f[i];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return c;
    endfunction

    // R2: build a frame at the stated positions
    function automatic logic [319:0] mk_frame(logic [15:0] fid, logic [15:0] card, int seed);
        logic [319:0] f = '0;
        f[319:304] = fid;
        f[303:288] = card;
        f[287:256] = 32'(seed * 7919);
        for (int k = 0; k < 8; k++) begin
            f[255-20*k -: 8]  = 8'(seed + k * 17);
            f[247-20*k -: 12] = 12'(seed * 3 + k * 301);
        end
        f[95:32] = {2{32'(seed) ^ 32'h5A5A_1234}};
        f[31:0]  = tb_crc(f);
        return f;
    endfunction

    function automatic item_t to_item(logic [319:0] f);
        item_t it;
        it.fid = f[319:304];
        for (int k = 0; k < 8; k++) begin
            it.cnts[63-8*k -: 8]  = f[255-20*k -: 8];
            it.adcs[95-12*k -: 12] = f[247-20*k -: 12];
        end
        return it;
    endfunction

    function automatic void sat_inc(int i, int amt);
        mc[i] = (mc[i] + amt > CMAX) ? CMAX : mc[i] + amt;
    endfunction

    // Expected effect of one period, from the requirements
    function automatic void model_period(logic [319:0] fa, logic [319:0] fb, bit pa, bit pb);
        logic [319:0] f[2];
        bit p[2], cok[2], vld[2], jmp[2];
        logic [15:0] gp[2];
        f[0] = fa; f[1] = fb; p[0] = pa; p[1] = pb;
        for (int k = 0; k < 2; k++) begin
            cok[k] = p[k] && (tb_crc(f[k]) == f[k][31:0]);
            vld[k] = cok[k] && (f[k][303:288] == CARD);
            jmp[k] = vld[k] && href[k] && (f[k][319:304] != eid[k]);
            gp[k]  = f[k][319:304] - eid[k];
        end
        if (p[0] && !cok[0]) sat_inc(0, 1);
        if (p[1] && !cok[1]) sat_inc(1, 1);
        if (cok[0] && cok[1] && fa[31:0] != fb[31:0]) sat_inc(2, 1);
        if ((cok[0] && !vld[0]) || (cok[1] && !vld[1])) sat_inc(3, 1);
        if (jmp[0] || jmp[1]) sat_inc(4, 1);
        for (int k = 0; k < 2; k++) begin
            if (!p[k]) sat_inc(5 + k, 1);
            else if (jmp[k]) sat_inc(5 + k, int'(gp[k]));
            if (vld[k]) begin
                eid[k] = f[k][319:304] + 16'd1;
                href[k] = 1'b1;
            end else if (href[k]) begin
                eid[k] = eid[k] + 16'd1;
            end
        end
        if (vld[0]) exp_q.push_back(to_item(fa));
        else if (vld[1]) exp_q.push_back(to_item(fb));
    endfunction

    task automatic check_counters(string req);
        chk(crc_err_a == TB_CNT_W'(mc[0]), req, "crc_err_a", crc_err_a, mc[0]);
        chk(crc_err_b == TB_CNT_W'(mc[1]), req, "crc_err_b", crc_err_b, mc[1]);
        chk(crc_diff  == TB_CNT_W'(mc[2]), req, "crc_diff",  crc_diff,  mc[2]);
        chk(card_err  == TB_CNT_W'(mc[3]), req, "card_err",  card_err,  mc[3]);
        chk(fid_err   == TB_CNT_W'(mc[4]), req, "fid_err",   fid_err,   mc[4]);
        chk(lost_a    == TB_CNT_W'(mc[5]), req, "lost_a",    lost_a,    mc[5]);
        chk(lost_b    == TB_CNT_W'(mc[6]), req, "lost_b",    lost_b,    mc[6]);
    endtask

    task automatic pulse(bit sa, bit sb, logic [319:0] fa, logic [319:0] fb);
        @(negedge clk);
        a_strobe = sa; b_strobe = sb; a_frame = fa; b_frame = fb;
        @(negedge clk);
        a_strobe = 1'b0; b_strobe = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic period(logic [319:0] fa, logic [319:0] fb, bit pa, bit pb, int skew, string req);
        model_period(fa, fb, pa, pb);
        if (pa && pb && skew == 0) begin
            pulse(1'b1, 1'b1, fa, fb);
        end else begin
            if (pa) pulse(1'b1, 1'b0, fa, fb);
            if (pb) begin
                settle(skew);
                pulse(1'b0, 1'b1, fa, fb);
            end
        end
        settle((pa && pb) ? 14 : TB_WAIT + 14);
        check_counters(req);
    endtask

    // Scoreboard monitor (R4)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected out_valid", 1, 0);
            end else begin
                item_t e;
                item_t a;
                e = exp_q.pop_front();
                a.fid = out_frame_id; a.cnts = out_counts; a.adcs = out_adcs;
                chk(a == e, "R4", "forwarded item", longint'(a.fid), longint'(e.fid));
                chk(a.cnts == e.cnts && a.adcs == e.adcs, "R2", "channel fields",
                    longint'(a.cnts), longint'(e.cnts));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [319:0] g, h;
        for (int i = 0; i < 7; i++) mc[i] = 0;
        href[0] = 0; href[1] = 0; eid[0] = '0; eid[1] = '0;

        settle(3);
        rst_n = 1'b1;
        settle(2);
        // R11: reset state
        chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
        check_counters("R11");

        // R6: exact latency, both strobes together, id 100
        g = mk_frame(16'd100, CARD, 5);
        model_period(g, g, 1, 1);
        pulse(1'b1, 1'b1, g, g);
        repeat (9) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6", "out_valid before latency", out_valid, 0);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b1, "R6", "out_valid at latency", out_valid, 1);
        settle(4);
        check_counters("R6");

        // R6: skewed arrival
        g = mk_frame(16'd101, CARD, 9);
        period(g, g, 1, 1, 3, "R6");

        // R1: A bad CRC, B forwarded
        g = mk_frame(16'd102, CARD, 13);
        period(g ^ 320'h1, g, 1, 1, 0, "R1");

        // R5/R4: both valid, differing -> A forwarded, disagreement counted
        period(mk_frame(16'd103, CARD, 21), mk_frame(16'd103, CARD, 22), 1, 1, 0, "R5");

        // R1: both bad, nothing forwarded
        g = mk_frame(16'd104, CARD, 30);
        period(g ^ 320'h2, g ^ 320'h4, 1, 1, 0, "R1");

        // R6: B missing, A missing
        g = mk_frame(16'd105, CARD, 31);
        period(g, g, 1, 0, 0, "R6");
        g = mk_frame(16'd106, CARD, 32);
        period(g, g, 0, 1, 0, "R6");

        // R3: wrong card on A
        period(mk_frame(16'd107, 16'hBEEF, 40), mk_frame(16'd107, CARD, 40), 1, 1, 0, "R3");

        // R7: frame number jump to 110 (expected 108)
        g = mk_frame(16'd110, CARD, 50);
        period(g, g, 1, 1, 0, "R7");

        // R10: second A strobe in open period ignored
        g = mk_frame(16'd111, CARD, 60);
        h = mk_frame(16'd111, CARD, 61);
        model_period(g, g, 1, 1);
        pulse(1'b1, 1'b0, g, g);
        pulse(1'b1, 1'b0, h, g);
        pulse(1'b0, 1'b1, h, g);
        settle(14);
        check_counters("R10");

        // R8: CRC counter saturation
        for (int n = 0; n < 14; n++) begin
            g = mk_frame(16'(112 + n), CARD, 70 + n);
            period(g ^ 320'h8, g, 1, 1, 0, "R8");
        end
        // R8: lost counter saturation by large jump
        g = mk_frame(16'd2000, CARD, 99);
        period(g, g, 1, 1, 0, "R8");

        // R9: clear
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        for (int i = 0; i < 7; i++) mc[i] = 0;
        check_counters("R9");

        // R9: references kept, next number continues without error
        g = mk_frame(16'd2001, CARD, 100);
        period(g, g, 1, 1, 0, "R9");

        settle(5);
        chk(exp_q.size() == 0, "R4", "outputs outstanding", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule